// File: doc/BRIEF.md
# Circular Queue Pointer Manager

This block keeps the head and tail pointers of four circular queues. The queues hold 32-bit frame addresses and share one memory region. The region begins at a base address aligned to 1 MiB. It is split into four slices of equal size, placed in a fixed order: inbound free (queue 0), inbound post (queue 1), outbound free (queue 2) and outbound post (queue 3). Each slice is `size << 11` bytes long.

A host reaches the queues through two port locations, selected by `h_sel`:

- **Inbound port (`h_sel`=0).** A read pops one entry from the inbound free queue. A write pushes one entry onto the inbound post queue.
- **Outbound port (`h_sel`=1).** A read pops one entry from the outbound post queue. A write pushes one entry onto the outbound free queue.

Queue entries are read and written through a simple memory master port. That port has a combinational read path and a write strobe, and it connects to an on-chip RAM.

The local processor uses a word-indexed register port. Through it the processor sets the size and enable bits, writes the base address (which also resets every pointer), and reads or writes any head or tail pointer. It also reads a status word and clears the sticky overflow flags in it. Flags for the interrupt unit report when either post queue is not empty and when either monitored queue has overflowed.

Top module: `qptr_mgr`

## Requirements
- R1: A local write of a base value whose low 20 bits are zero stores that base. It also sets the head and tail of every queue q (0..3) to base + q*(size<<11). The size is the control field at bits 5:1 at the time of the write.
- R2: A local write of a base value with any of the low 20 bits set has no effect. The base register and all pointers keep their values.
- R3: A host read of the inbound port, with the inbound free queue not empty, returns the memory word at that queue's tail. The value appears on `h_rdata` one clock after the request. The tail advances by 4.
- R4: A host write to the inbound port stores the data at the inbound post head and advances that head by 4. The memory write strobe is active only for such committed pushes.
- R5: A host read of the outbound port pops the outbound post queue in the same way. A host write to the outbound port pushes onto the outbound free queue.
- R6: A pop from a queue whose head equals its tail returns 0xFFFFFFFF and leaves the pointers unchanged.
- R7: A pointer that steps past the last word of its own slice returns to the first word of that slice. This applies to both pops and pushes.
- R8: A push whose advanced head would equal the tail is not committed: memory and the head do not change. A push of this kind sets a sticky flag, status bit 7 for the inbound post queue or status bit 8 for the outbound free queue. Each flag has its own output.
- R9: A local write to the status word clears each overflow flag whose bit (7 or 8) is 1 in the written data. Flags whose bit is 0 are left as they are.
- R10: While control bit 0 (enable) is 0, host reads return 0xFFFFFFFF and host writes change nothing. This includes the overflow flags.
- R11: `in_post_ne_o` (and status bit 5) is 1 exactly when the inbound post head differs from its tail. `out_post_ne_o` is 1 exactly when the outbound post head differs from its tail.
- R12: Local register map, by word index: 0 base, 1 control, 2+2q head of queue q, 3+2q tail of queue q, 10 status. Pointer registers can be read and written from the local port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_req | input | 1 | Host port access strobe |
| h_we | input | 1 | Host access is a write (push) |
| h_sel | input | 1 | 0 selects the inbound port, 1 selects the outbound port |
| h_wdata | input | 32 | Frame address to push |
| h_rdata | output | 32 | Popped frame address, or all ones, valid one clock after a read |
| l_req | input | 1 | Local register access strobe |
| l_we | input | 1 | Local access is a write |
| l_addr | input | 4 | Local register word index |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data (combinational) |
| m_we | output | 1 | Memory write strobe |
| m_addr | output | 32 | Memory byte address |
| m_wdata | output | 32 | Memory write data |
| m_rdata | input | 32 | Memory read data (combinational) |
| in_post_ne_o | output | 1 | Inbound post queue not empty |
| out_post_ne_o | output | 1 | Outbound post queue not empty |
| ovf_in_post_o | output | 1 | Sticky inbound post overflow |
| ovf_out_free_o | output | 1 | Sticky outbound free overflow |

## Verification
A wrong pointer shows up at the ports on the very next host access. A pop returns the wrong word or a premature all-ones value, and a push strobes a memory address outside its slice. A wrong pointer also flips a not-empty flag in the same cycle it is committed, and it can be read back directly through the local pointer registers. Wrap and overflow faults appear only at slice edges. The bench therefore places pointers right next to those edges and checks the returned word, the written RAM word and the flag outputs after a single access.

// File: rtl/qptr_mgr.sv
module qptr_mgr #(
  parameter int DW    = 32,
  parameter int SZW   = 5,
  parameter int QSH   = 11,
  parameter int ALIGN = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_req,
  input  logic          h_we,
  input  logic          h_sel,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic          l_req,
  input  logic          l_we,
  input  logic [3:0]    l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          m_we,
  output logic [DW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata,
  output logic          in_post_ne_o,
  output logic          out_post_ne_o,
  output logic          ovf_in_post_o,
  output logic          ovf_out_free_o
);
  localparam int NQ   = 4;
  localparam int CW   = SZW + 1;
  localparam logic [DW-1:0] STEP = DW'(4);

  logic [DW-1:0] base_q;
  logic [CW-1:0] ctrl_q;
  logic [DW-1:0] head_q [NQ];
  logic [DW-1:0] tail_q [NQ];
  logic          ovf_ip_q, ovf_of_q;
  logic [DW-1:0] rdata_q;

  logic [DW-1:0] qbytes;
  assign qbytes = DW'(ctrl_q[CW-1:1]) << QSH;

  function automatic logic [DW-1:0] slice_start(input logic [DW-1:0] b,
                                                input logic [DW-1:0] qb,
                                                input int q);
    return b + DW'(q) * qb;
  endfunction

  function automatic logic [DW-1:0] advance(input logic [DW-1:0] p,
                                            input logic [DW-1:0] b,
                                            input logic [DW-1:0] qb,
                                            input int q);
    logic [DW-1:0] n;
    n = p + STEP;
    return (n == slice_start(b, qb, q + 1)) ? slice_start(b, qb, q) : n;
  endfunction

  wire en = ctrl_q[0];
  wire [1:0] pop_q  = h_sel ? 2'd3 : 2'd0;
  wire [1:0] push_q = h_sel ? 2'd2 : 2'd1;

  logic [DW-1:0] push_next, pop_next;
  logic          pop_ne, push_full;
  always_comb begin
    push_next = advance(head_q[push_q], base_q, qbytes, int'(push_q));
    pop_next  = advance(tail_q[pop_q], base_q, qbytes, int'(pop_q));
    pop_ne    = head_q[pop_q] != tail_q[pop_q];
    push_full = push_next == tail_q[push_q];
  end

  wire host_rd  = h_req && !h_we;
  wire host_wr  = h_req && h_we && en;
  wire do_pop   = host_rd && en && pop_ne;
  wire do_push  = host_wr && !push_full;
  wire ovf_hit  = host_wr && push_full;

  assign m_we    = do_push;
  assign m_addr  = h_we ? head_q[push_q] : tail_q[pop_q];
  assign m_wdata = h_wdata;
  assign h_rdata = rdata_q;

  wire lw        = l_req && l_we;
  wire base_ok   = l_wdata[ALIGN-1:0] == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      ctrl_q   <= '0;
      ovf_ip_q <= 1'b0;
      ovf_of_q <= 1'b0;
      rdata_q  <= '0;
      for (int q = 0; q < NQ; q++) begin
        head_q[q] <= '0;
        tail_q[q] <= '0;
      end
    end else begin
      if (lw) begin
        case (l_addr)
          4'd0: if (base_ok) begin
            base_q <= l_wdata;
            for (int q = 0; q < NQ; q++) begin
              head_q[q] <= slice_start(l_wdata, qbytes, q);
              tail_q[q] <= slice_start(l_wdata, qbytes, q);
            end
          end
          4'd1: ctrl_q <= l_wdata[CW-1:0];
          4'd10: begin
            if (l_wdata[7]) ovf_ip_q <= 1'b0;
            if (l_wdata[8]) ovf_of_q <= 1'b0;
          end
          default: begin
            for (int q = 0; q < NQ; q++) begin
              if (l_addr == 4'(2 + 2*q)) head_q[q] <= l_wdata;
              if (l_addr == 4'(3 + 2*q)) tail_q[q] <= l_wdata;
            end
          end
        endcase
      end
      if (host_rd) rdata_q <= do_pop ? m_rdata : '1;
      if (do_pop)  tail_q[pop_q]  <= pop_next;
      if (do_push) head_q[push_q] <= push_next;
      if (ovf_hit && !h_sel) ovf_ip_q <= 1'b1;
      if (ovf_hit &&  h_sel) ovf_of_q <= 1'b1;
    end
  end

  assign in_post_ne_o   = head_q[1] != tail_q[1];
  assign out_post_ne_o  = head_q[3] != tail_q[3];
  assign ovf_in_post_o  = ovf_ip_q;
  assign ovf_out_free_o = ovf_of_q;

  always_comb begin
    l_rdata = '0;
    case (l_addr)
      4'd0:  l_rdata = base_q;
      4'd1:  l_rdata = DW'(ctrl_q);
      4'd10: l_rdata = DW'({ovf_of_q, ovf_ip_q, 1'b0, in_post_ne_o, 5'b0});
      default: begin
        for (int q = 0; q < NQ; q++) begin
          if (l_addr == 4'(2 + 2*q)) l_rdata = head_q[q];
          if (l_addr == 4'(3 + 2*q)) l_rdata = tail_q[q];
        end
      end
    endcase
  end
endmodule

// File: rtl/qptr_mgr_chk.sv
module qptr_mgr_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_req,
  input logic          h_we,
  input logic          h_sel,
  input logic          en,
  input logic          m_we,
  input logic [DW-1:0] m_addr,
  input logic [DW-1:0] h_rdata,
  input logic          ovf_ip,
  input logic          ovf_of
);
  assert_disabled_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && !h_we && !en) |=> (h_rdata == '1));

  assert_write_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_we |-> (h_req && h_we && en));

  assert_word_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_we |-> (m_addr[1:0] == 2'b00));

  assert_ovf_ip_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_ip) |-> $past(h_req && h_we && !h_sel && en));

  assert_ovf_of_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_of) |-> $past(h_req && h_we && h_sel && en));
endmodule

bind qptr_mgr qptr_mgr_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_sel(h_sel),
  .en(ctrl_q[0]), .m_we(m_we), .m_addr(m_addr), .h_rdata(h_rdata),
  .ovf_ip(ovf_ip_q), .ovf_of(ovf_of_q)
);

// File: tb/qptr_mgr_test.sv
module qptr_mgr_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_req = 0, h_we = 0, h_sel = 0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic l_req = 0, l_we = 0;
  logic [3:0] l_addr = '0;
  logic [31:0] l_wdata = '0;
  logic [31:0] l_rdata;
  logic m_we;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic in_post_ne_o, out_post_ne_o, ovf_in_post_o, ovf_out_free_o;

  logic [31:0] ram [2048];
  logic bd_we = 0;
  logic [10:0] bd_idx = '0;
  logic [31:0] bd_data = '0;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (m_we) ram[m_addr[12:2]] <= m_wdata;
    else if (bd_we) ram[bd_idx] <= bd_data;
  end
  assign m_rdata = ram[m_addr[12:2]];

  qptr_mgr uut (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_sel(h_sel),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .l_req(l_req), .l_we(l_we),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .m_we(m_we),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .in_post_ne_o(in_post_ne_o), .out_post_ne_o(out_post_ne_o),
    .ovf_in_post_o(ovf_in_post_o), .ovf_out_free_o(ovf_out_free_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic host(input logic we, input logic sel, input logic [31:0] d,
                      output logic [31:0] r);
    @(negedge clk);
    h_req = 1; h_we = we; h_sel = sel; h_wdata = d;
    @(negedge clk);
    r = h_rdata;
    h_req = 0; h_we = 0;
  endtask

  task automatic lwr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    l_req = 1; l_we = 1; l_addr = a; l_wdata = d;
    @(negedge clk);
    l_req = 0; l_we = 0;
  endtask

  task automatic lrd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    l_req = 1; l_we = 0; l_addr = a;
    #1 d = l_rdata;
    l_req = 0;
  endtask

  task automatic poke(input int idx, input logic [31:0] d);
    @(negedge clk);
    bd_we = 1; bd_idx = 11'(idx); bd_data = d;
    @(negedge clk);
    bd_we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // {op[1:0], data, expected}; op: 0 in-read, 1 in-write, 2 out-read, 3 out-write
  localparam int NV = 10;
  localparam logic [65:0] VEC [NV] = '{
    {2'd0, 32'h0, 32'hA000_0001},
    {2'd3, 32'hC000_0001, 32'h0},
    {2'd0, 32'h0, 32'hA000_0002},
    {2'd1, 32'hD000_0001, 32'h0},
    {2'd2, 32'h0, 32'hB000_0001},
    {2'd0, 32'h0, 32'hA000_0003},
    {2'd0, 32'h0, ONES},
    {2'd2, 32'h0, 32'hB000_0002},
    {2'd2, 32'h0, ONES},
    {2'd1, 32'hD000_0002, 32'h0}
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    lrd(4'd0, r);  chk("R12 reset base", r, 32'h0);
    lrd(4'd1, r);  chk("R12 reset control", r, 32'h0);
    lrd(4'd10, r); chk("R11 reset status", r, 32'h0);
    chk("R11 reset flags", {28'h0, in_post_ne_o, out_post_ne_o, ovf_in_post_o, ovf_out_free_o}, 32'h0);
    chk("R3 reset rdata", h_rdata, 32'h0);
    rst_n = 1;

    lwr(4'd1, 32'h2);
    lwr(4'd0, BASE);
    lrd(4'd4, r); chk("R1 ip head", r, BASE + 32'h800);
    lrd(4'd9, r); chk("R1 op tail", r, BASE + 32'h1800);
    poke(0, 32'hA000_0001); poke(1, 32'hA000_0002); poke(2, 32'hA000_0003);
    poke(32'h600, 32'hB000_0001); poke(32'h601, 32'hB000_0002);
    lwr(4'd2, BASE + 32'hC);
    lwr(4'd8, BASE + 32'h1808);
    lwr(4'd1, 32'h3);
    lrd(4'd2, r); chk("R12 if head write", r, BASE + 32'hC);
    #1 chk("R11 out post ne", {31'h0, out_post_ne_o}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      host(VEC[i][64], VEC[i][65], VEC[i][63:32], r);
      if (!VEC[i][64]) chk($sformatf("R3 R5 R6 vector %0d", i), r, VEC[i][31:0]);
    end

    lrd(4'd4, r); chk("R4 ip head", r, BASE + 32'h808);
    lrd(4'd6, r); chk("R5 of head", r, BASE + 32'h1004);
    lrd(4'd3, r); chk("R3 if tail", r, BASE + 32'hC);
    lrd(4'd9, r); chk("R5 op tail", r, BASE + 32'h1808);
    chk("R4 ram ip0", ram[32'h200], 32'hD000_0001);
    chk("R4 ram ip1", ram[32'h201], 32'hD000_0002);
    chk("R5 ram of0", ram[32'h400], 32'hC000_0001);
    #1 chk("R11 in post ne", {31'h0, in_post_ne_o}, 32'h1);
    chk("R11 out post empty", {31'h0, out_post_ne_o}, 32'h0);
    lrd(4'd10, r); chk("R11 status bit5", r, 32'h20);

    poke(32'h1FF, 32'hEEEE_0001);
    lwr(4'd3, BASE + 32'h7FC);
    lwr(4'd2, BASE);
    host(0, 0, 0, r); chk("R7 pop last word", r, 32'hEEEE_0001);
    lrd(4'd3, r); chk("R7 pop wrap tail", r, BASE);
    host(0, 0, 0, r); chk("R6 empty pop", r, ONES);
    lrd(4'd3, r); chk("R6 tail unchanged", r, BASE);

    lwr(4'd6, BASE + 32'h17FC);
    lwr(4'd7, BASE + 32'h1004);
    host(1, 1, 32'hCCCC_0002, r);
    chk("R7 push last word", ram[32'h5FF], 32'hCCCC_0002);
    lrd(4'd6, r); chk("R7 push wrap head", r, BASE + 32'h1000);

    lwr(4'd5, BASE + 32'h80C);
    host(1, 0, 32'hD000_0003, r);
    #1 chk("R8 ip ovf flag", {31'h0, ovf_in_post_o}, 32'h1);
    lrd(4'd4, r); chk("R8 ip head held", r, BASE + 32'h808);
    chk("R8 ip ram untouched", {31'h0, ram[32'h202] === 32'hD000_0003}, 32'h0);
    lrd(4'd10, r); chk("R8 status bit7", r, 32'hA0);
    host(1, 1, 32'hCCCC_0003, r);
    #1 chk("R8 of ovf flag", {31'h0, ovf_out_free_o}, 32'h1);
    lrd(4'd6, r); chk("R8 of head held", r, BASE + 32'h1000);
    lrd(4'd10, r); chk("R8 status bit8", r, 32'h1A0);

    lwr(4'd10, 32'h80);
    lrd(4'd10, r); chk("R9 clear bit7 only", r, 32'h120);
    lwr(4'd10, 32'h100);
    lrd(4'd10, r); chk("R9 clear bit8", r, 32'h20);

    lwr(4'd2, BASE + 32'h4);
    poke(0, 32'hA000_0001);
    lwr(4'd1, 32'h2);
    host(0, 0, 0, r); chk("R10 disabled read", r, ONES);
    lrd(4'd3, r); chk("R10 if tail held", r, BASE);
    host(1, 1, 32'h1234_5678, r);
    lrd(4'd6, r); chk("R10 of head held", r, BASE + 32'h1000);
    #1 chk("R10 no ovf while off", {31'h0, ovf_out_free_o}, 32'h0);
    host(1, 0, 32'h1234_5678, r);
    lrd(4'd4, r); chk("R10 ip head held", r, BASE + 32'h808);
    lwr(4'd1, 32'h3);
    host(0, 0, 0, r); chk("R3 read after enable", r, 32'hA000_0001);

    lwr(4'd0, 32'h0018_0000);
    lrd(4'd0, r); chk("R2 base held", r, BASE);
    lrd(4'd2, r); chk("R2 if head held", r, BASE + 32'h4);

    lwr(4'd1, 32'h4);
    lwr(4'd0, 32'h0030_0000);
    for (int q = 0; q < 4; q++) begin
      lrd(4'(2 + 2*q), r); chk($sformatf("R1 head %0d", q), r, 32'h0030_0000 + 32'(q) * 32'h1000);
      lrd(4'(3 + 2*q), r); chk($sformatf("R1 tail %0d", q), r, 32'h0030_0000 + 32'(q) * 32'h1000);
    end
    lrd(4'd0, r); chk("R1 base stored", r, 32'h0030_0000);

    finish_run();
  end
endmodule